// File: doc/BRIEF.md
# Programmable I/O Chip-Select Decoder

This block produces one general-purpose, active-low chip-select for a single host I/O address that software programs. Two configuration registers sit behind an index/data pair. One port selects a register by index and the other reads or writes it. The low register holds the eight least significant address bits to match. The high register holds the upper three address bits, separate enables for read and write qualification, a switch that includes or excludes the top address bit from the compare, and a select that sets what the shared pin does.

The select follows the host bus combinationally. It goes low only when all of the following hold: the pin is in chip-select mode, the cycle is not a DMA cycle, an enabled strobe is low, and the address matches. When the shared pin is set to its other function, a system-clock input, the select stays high, its driver is disabled, and the pin level is passed through to the clock consumer.

Top module: `io_csel_decoder`

## Requirements
- R1: After a synchronous reset, the index register, the low register and the high register are all zero, `cs_n` is 1 and `cs_oe` is 0.
- R2: A write with `cfg_sel`=0 loads the index. A write with `cfg_sel`=1 loads the register that the index selects (index 0x20 is the low register, 0x21 is the high register). Reading with `cfg_sel`=1 returns that register, reading with `cfg_sel`=0 returns the index, and any other index reads as zero.
- R3: High register bit 3 is reserved. It always reads 0, and writing 1 to it has no effect.
- R4: With high bit 6 set, the select asserts only when host address bits 10..0 equal {high[2:0], low[7:0]}.
- R5: With high bit 6 clear, address bit 10 is ignored, and bits 9..0 must equal {high[1:0], low[7:0]}.
- R6: High bit 5 enables assertion while `host_rd_n` is low. With bit 5 clear, a read never asserts the select.
- R7: High bit 4 enables assertion while `host_wr_n` is low. With bit 4 clear, a write never asserts the select.
- R8: While `host_dma` is 1, `cs_n` stays 1 regardless of address and strobes.
- R9: With both strobes high, `cs_n` is 1. The select follows strobe and address changes in the same cycle, with no clock delay.
- R10: With high bit 7 clear (clock-input mode), `cs_n` is 1, `cs_oe` is 0 and `sys_clk_out` equals `sys_clk_pin`.
- R11: With high bit 7 set (chip-select mode), `cs_oe` is 1 and `sys_clk_out` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| host_addr | input | 11 | Host I/O address |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_dma | input | 1 | 1 marks the current cycle as a DMA cycle |
| sys_clk_pin | input | 1 | Level on the shared pin when it acts as clock input |
| sys_clk_out | output | 1 | System clock to internal logic |
| cs_n | output | 1 | Chip-select, active low |
| cs_oe | output | 1 | Output enable for the shared pin |

## Verification
Every configuration bit acts on the select combinationally, so a corrupted register value shows on `cs_n` or `cs_oe` at the first bus cycle that exercises it. It also shows on `cfg_rdata` as soon as that register is read back. A wrong index selects the wrong register, which shows up as a mismatched read-back value. A bad compare mask or a bad strobe qualification shows up as a select firing on a neighbour address, on the wrong strobe or during DMA, within the same bus cycle. The random patterns bias addresses toward the programmed one, flipping bit 10 in particular, so mask faults show up within a few dozen patterns.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int ADDR_W = 11;
  localparam int LO_W   = 8;
  localparam int HI_AW  = ADDR_W - LO_W;

  typedef struct packed {
    logic             pin_cs;
    logic             full_dec;
    logic             en_rd;
    logic             en_wr;
    logic             rsv;
    logic [HI_AW-1:0] a_hi;
  } hi_cfg_t;
endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
  import csd_pkg::*;
#(
  parameter int            DW     = 8,
  parameter logic [DW-1:0] LO_IDX = 8'h20,
  parameter logic [DW-1:0] HI_IDX = 8'h21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_sel,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic [LO_W-1:0] lo_q,
  output hi_cfg_t       hi_q
);
  logic [DW-1:0] idx_q;
  hi_cfg_t       hi_wr;

  always_comb begin
    hi_wr     = hi_cfg_t'(cfg_wdata);
    hi_wr.rsv = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) idx_q <= cfg_wdata;
      else if (idx_q == LO_IDX) lo_q <= cfg_wdata[LO_W-1:0];
      else if (idx_q == HI_IDX) hi_q <= hi_wr;
    end
  end

  always_comb begin
    if (!cfg_sel)               cfg_rdata = idx_q;
    else if (idx_q == LO_IDX)   cfg_rdata = DW'(lo_q);
    else if (idx_q == HI_IDX)   cfg_rdata = DW'(hi_q);
    else                        cfg_rdata = '0;
  end

  // R1: reset clears all configuration state
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (idx_q == '0 && lo_q == '0 && hi_q == '0));

  // R2: a data write to the low register lands there
  assert_lo_write_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel && idx_q == LO_IDX) |=> lo_q == $past(cfg_wdata[LO_W-1:0]));

  // R3: reserved bit never becomes set in storage
  assert_rsv_clear_R3: assert property (@(posedge clk) disable iff (rst)
    hi_q.rsv == 1'b0);
endmodule

// File: rtl/csd_addr_match.sv
module csd_addr_match
  import csd_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          full_dec,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ref_addr,
  output logic          hit
);
  logic [AW-1:0] care;
  logic [AW-1:0] eq;

  assign care = {full_dec, {(AW-1){1'b1}}};

  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign eq[b] = (addr[b] == ref_addr[b]) || !care[b];
  end

  assign hit = &eq;
endmodule

// File: rtl/csd_strobe_qual.sv
module csd_strobe_qual (
  input  logic rd_n,
  input  logic wr_n,
  input  logic dma,
  input  logic en_rd,
  input  logic en_wr,
  output logic qual
);
  logic rd_act;
  logic wr_act;

  assign rd_act = !rd_n && en_rd;
  assign wr_act = !wr_n && en_wr;
  assign qual   = !dma && (rd_act || wr_act);
endmodule

// File: rtl/io_csel_decoder.sv
module io_csel_decoder
  import csd_pkg::*;
#(
  parameter int          DW     = 8,
  parameter logic [7:0]  LO_IDX = 8'h20,
  parameter logic [7:0]  HI_IDX = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_sel,
  input  logic              cfg_we,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_dma,
  input  logic              sys_clk_pin,
  output logic              sys_clk_out,
  output logic              cs_n,
  output logic              cs_oe
);
  logic [LO_W-1:0] lo_q;
  hi_cfg_t         hi_q;
  logic            hit;
  logic            qual;

  csd_cfg_regs #(.DW(DW), .LO_IDX(DW'(LO_IDX)), .HI_IDX(DW'(HI_IDX))) u_regs (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lo_q(lo_q), .hi_q(hi_q)
  );

  csd_addr_match #(.AW(ADDR_W)) u_match (
    .full_dec(hi_q.full_dec), .addr(host_addr),
    .ref_addr({hi_q.a_hi, lo_q}), .hit(hit)
  );

  csd_strobe_qual u_qual (
    .rd_n(host_rd_n), .wr_n(host_wr_n), .dma(host_dma),
    .en_rd(hi_q.en_rd), .en_wr(hi_q.en_wr), .qual(qual)
  );

  assign cs_oe       = hi_q.pin_cs;
  assign cs_n        = !(hi_q.pin_cs && hit && qual);
  assign sys_clk_out = hi_q.pin_cs ? 1'b1 : sys_clk_pin;

  // R8: DMA cycles never select
  assert_dma_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    host_dma |-> cs_n);

  // R9: no strobe, no select
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (host_rd_n && host_wr_n) |-> cs_n);

  // R10: clock-input mode keeps the select off and passes the pin through
  assert_clk_mode_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_oe |-> (cs_n && sys_clk_out == sys_clk_pin));

  // R6 and R7: an active select is backed by an enabled strobe
  assert_strobe_enable_R6: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> ((!host_rd_n && hi_q.en_rd) || (!host_wr_n && hi_q.en_wr)));

  // R4: an active select implies the low address bits match
  assert_addr_match_R4: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> host_addr[9:0] == {hi_q.a_hi[1:0], lo_q});
endmodule

// File: tb/sim_io_csel_decoder.sv
module sim_io_csel_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_sel, cfg_we;
  logic [7:0]  cfg_wdata, cfg_rdata;
  logic [10:0] host_addr;
  logic        host_rd_n, host_wr_n, host_dma, sys_clk_pin;
  logic        sys_clk_out, cs_n, cs_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  io_csel_decoder u0 (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_addr(host_addr),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_dma(host_dma),
    .sys_clk_pin(sys_clk_pin), .sys_clk_out(sys_clk_out),
    .cs_n(cs_n), .cs_oe(cs_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_cs_n(input logic [7:0] lo, input logic [7:0] hi,
                                    input logic [10:0] a, input logic rd_n,
                                    input logic wr_n, input logic dma);
    logic m, q;
    m = (a[7:0] == lo) && (a[9:8] == hi[1:0]) && (!hi[6] || a[10] == hi[2]);
    q = !dma && ((!rd_n && hi[5]) || (!wr_n && hi[4]));
    return !(hi[7] && m && q);
  endfunction

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    cfg_write(1'b0, idx);
    cfg_write(1'b1, d);
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] d);
    cfg_write(1'b0, idx);
    cfg_sel = 1'b1; #1; d = cfg_rdata;
  endtask

  task automatic bus(input logic [10:0] a, input logic rd_n, input logic wr_n, input logic dma);
    host_addr = a; host_rd_n = rd_n; host_wr_n = wr_n; host_dma = dma; #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, lo, hi;
    void'($urandom(32'h5EED));
    rst = 1'b1; cfg_sel = 0; cfg_we = 0; cfg_wdata = 0;
    host_addr = 0; host_rd_n = 1; host_wr_n = 1; host_dma = 0; sys_clk_pin = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 cs_n", cs_n, 1'b1);
    check("R1 cs_oe", cs_oe, 1'b0);
    check("R1 index", cfg_rdata, 8'h00);
    read_reg(8'h21, rd); check("R1 high reg", rd, 8'h00);
    read_reg(8'h20, rd); check("R1 low reg", rd, 8'h00);

    set_reg(8'h20, 8'hA5); read_reg(8'h20, rd); check("R2 low readback", rd, 8'hA5);
    cfg_sel = 0; #1; check("R2 index readback", cfg_rdata, 8'h20);
    set_reg(8'h33, 8'h77); read_reg(8'h33, rd); check("R2 unused index", rd, 8'h00);
    read_reg(8'h20, rd); check("R2 low untouched", rd, 8'hA5);

    set_reg(8'h21, 8'hFF); read_reg(8'h21, rd); check("R3 reserved zero", rd, 8'hF7);

    // R4 full decode: high 0xF5 (cs pin, full, rd, wr, A10..8 = 101), low 0x3C
    set_reg(8'h20, 8'h3C); set_reg(8'h21, 8'hF5);
    bus({3'b101, 8'h3C}, 0, 1, 0); check("R4 match", cs_n, 1'b0);
    bus({3'b001, 8'h3C}, 0, 1, 0); check("R4 A10 differs", cs_n, 1'b1);
    bus({3'b101, 8'h3D}, 0, 1, 0); check("R4 A0 differs", cs_n, 1'b1);
    check("R11 cs_oe", cs_oe, 1'b1);
    sys_clk_pin = 0; #1; check("R11 clk held", sys_clk_out, 1'b1);

    set_reg(8'h21, 8'hB5);
    bus({3'b001, 8'h3C}, 1, 0, 0); check("R5 A10 ignored", cs_n, 1'b0);
    bus({3'b111, 8'h3C}, 1, 0, 0); check("R5 A9 compared", cs_n, 1'b1);

    set_reg(8'h21, 8'hA5);
    bus({3'b101, 8'h3C}, 0, 1, 0); check("R6 read enabled", cs_n, 1'b0);
    bus({3'b101, 8'h3C}, 1, 0, 0); check("R6 write blocked", cs_n, 1'b1);

    set_reg(8'h21, 8'h95);
    bus({3'b101, 8'h3C}, 1, 0, 0); check("R7 write enabled", cs_n, 1'b0);
    bus({3'b101, 8'h3C}, 0, 1, 0); check("R7 read blocked", cs_n, 1'b1);

    set_reg(8'h21, 8'hF5);
    bus({3'b101, 8'h3C}, 0, 0, 1); check("R8 dma", cs_n, 1'b1);
    bus({3'b101, 8'h3C}, 1, 1, 0); check("R9 idle", cs_n, 1'b1);
    host_rd_n = 0; #1; check("R9 same-cycle follow", cs_n, 1'b0);
    host_rd_n = 1; #1; check("R9 release", cs_n, 1'b1);

    set_reg(8'h21, 8'h75);
    bus({3'b101, 8'h3C}, 0, 0, 0);
    check("R10 cs_n", cs_n, 1'b1);
    check("R10 cs_oe", cs_oe, 1'b0);
    sys_clk_pin = 1; #1; check("R10 clk pass 1", sys_clk_out, 1'b1);
    sys_clk_pin = 0; #1; check("R10 clk pass 0", sys_clk_out, 1'b0);
    bus(11'h0, 1, 1, 0);

    lo = 8'h3C; hi = 8'h75;
    for (int i = 0; i < 600; i++) begin
      logic [10:0] a;
      if (i % 10 == 0) begin
        lo = 8'($urandom); hi = 8'($urandom) | 8'h80;
        if ($urandom_range(0, 3) == 0) hi[7] = 1'b0;
        set_reg(8'h20, lo); set_reg(8'h21, hi);
        hi[3] = 1'b0;
      end
      a = 11'($urandom);
      if ($urandom_range(0, 1) == 1) a = {1'($urandom), hi[1:0], lo};
      @(negedge clk);
      bus(a, 1'($urandom), 1'($urandom), ($urandom_range(0, 5) == 0));
      check("R4 R5 R6 R7 R8 random", cs_n,
            exp_cs_n(lo, hi, a, host_rd_n, host_wr_n, host_dma));
      check("R10 R11 random oe", cs_oe, hi[7]);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule